// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This unit keeps the eight-bit status byte of a serial nonvolatile memory and decides, in the same cycle as each write request, whether that request may proceed. A command decoder in front of it supplies one-cycle strobes for the decoded instructions: set the write latch, clear the latch and user flag, set the user flag, and start a status write. The array write path supplies a request with its target byte address. The write timer supplies a busy level and a completion strobe. The unit returns the status byte for readback, a grant for array writes and a grant for status writes.

Array protection is a lock code that covers none, the upper quarter, the upper half or all of the array. Status writes can also be blocked by an active-low protect pin, but only while the protect-enable bit is set. A granted status write is held in a pending register and reaches the status byte when the write timer signals completion. The pin is therefore judged once, when the write starts. The bits that are nonvolatile in silicon are plain registers here, loaded from parameters at reset.

Top module: `nvm_status_guard`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0: protect-enable, user flag, a constant 1, a constant 1, lock bit 1, lock bit 0, write latch, write-in-progress.
- R2: The lock code (status bits 3:2) marks a region of the array as locked: 00 locks nothing, 01 locks addresses whose two top bits are 11, 10 locks addresses whose top bit is 1, and 11 locks every address. An array request to a locked address is never granted. Locking has no effect on reads.
- R3: While the write latch is 0, neither an array request nor a status-write request is granted.
- R4: While the latch is 1, protect-enable is 1 and `wp_n` is 0, a status-write request is refused and an array request to an unlocked address is granted.
- R5: While the latch is 1 and either protect-enable is 0 or `wp_n` is 1, a status-write request is granted in the same cycle, and array requests to unlocked addresses are granted.
- R6: The set-latch strobe (opcode 0x06) sets the latch on the next cycle. The clear strobe (opcode 0x04) and the completion strobe `wr_done` clear it. Both clearing sources take priority over the set strobe in the same cycle.
- R7: The set-flag strobe (opcode 0x00) sets the user flag. The clear strobe clears the flag as well as the latch, and wins over set-flag in the same cycle.
- R8: A granted status write captures data bits 7, 6, 3 and 2. These bits are written into protect-enable, flag and lock when `wr_done` arrives, and those status bits change at no other time. A later change of `wp_n` does not cancel the captured write. A refused request captures nothing. Data bits 5, 4, 1 and 0 are ignored.
- R9: The write-in-progress bit shows `wr_busy` delayed by one clock.
- R10: Synchronous reset clears the latch, the flag and write-in-progress, and loads protect-enable and the lock code from parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, stands for power-up |
| cmd_wren | input | 1 | Decoded set-latch strobe |
| cmd_wrdi | input | 1 | Decoded clear strobe for latch and flag |
| cmd_setflag | input | 1 | Decoded set-flag strobe |
| cmd_stwr | input | 1 | Status-write start request |
| st_wdata | input | 8 | Data byte for a status write |
| arr_wr_req | input | 1 | Array write start request |
| arr_addr | input | ADDR_W | Target byte address of the array write |
| wp_n | input | 1 | Protect pin, active low |
| wr_busy | input | 1 | Busy level from the write timer |
| wr_done | input | 1 | Write completion strobe |
| status | output | 8 | Status byte for readback |
| arr_grant | output | 1 | Array write may proceed |
| st_grant | output | 1 | Status write may proceed |

## Verification
Several grant rules are checked on every cycle by properties: refusal of both grants while the latch is clear, the status-write rules for each combination of protect-enable and pin, the ban on array grants to a locked address, the next-cycle effect of each latch and flag strobe, the stability of the writable bits between commits, and the one-cycle delay of write-in-progress. Other behaviour needs the bench's scenarios. These include the exact lock boundaries for every code across the whole address space, the reset value of the byte, the survival of a captured write across a falling pin, and the fact that ignored data bits and refused requests leave the byte untouched.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;

  // writable part of the status byte
  typedef struct packed {
    logic       wpen;
    logic       flag;
    logic [1:0] lock;
  } nv_bits_t;

  // assemble the readback byte
  function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel,
                                             input logic wip);
    return {nv.wpen, nv.flag, 2'b11, nv.lock, wel, wip};
  endfunction

  // extract the writable fields from a data byte
  function automatic nv_bits_t nv_from_byte(input logic [7:0] b);
    nv_bits_t r;
    r.wpen = b[7];
    r.flag = b[6];
    r.lock = b[3:2];
    return r;
  endfunction

  // status write permission for the latch, enable and pin
  function automatic logic st_write_ok(input logic wel, input logic wpen, input logic pin_n);
    return wel & ~(wpen & ~pin_n);
  endfunction

endpackage

// File: rtl/nvm_lock_decode.sv
module nvm_lock_decode #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lock,
  output logic              locked
);
  localparam logic [ADDR_W:0] TOP_END   = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF_BASE = TOP_END >> 1;
  localparam logic [ADDR_W:0] QTR_BASE  = HALF_BASE + (HALF_BASE >> 1);

  logic [ADDR_W:0] floor_addr;

  generate
    if (ADDR_W < 2) begin : g_too_small
      $error("nvm_lock_decode: ADDR_W must be at least 2");
    end
  endgenerate

  // lowest locked address for each code; TOP_END means none
  always_comb begin
    unique case (lock)
      2'b00:   floor_addr = TOP_END;
      2'b01:   floor_addr = QTR_BASE;
      2'b10:   floor_addr = HALF_BASE;
      default: floor_addr = '0;
    endcase
  end

  assign locked = ({1'b0, addr} >= floor_addr);

endmodule

// File: rtl/nvm_status_regs.sv
module nvm_status_regs
  import nvm_status_pkg::*;
#(
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_LOCK = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       cmd_setflag,
  input  logic       st_grant,
  input  logic [7:0] st_wdata,
  input  logic       wr_busy,
  input  logic       wr_done,
  output nv_bits_t   nv,
  output logic       wel,
  output logic       wip,
  output logic       commit_evt
);
  nv_bits_t pend;
  logic     pend_valid;

  assign commit_evt = wr_done & pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel        <= 1'b0;
      wip        <= 1'b0;
      nv.wpen    <= RST_WPEN;
      nv.flag    <= 1'b0;
      nv.lock    <= RST_LOCK;
      pend       <= '0;
      pend_valid <= 1'b0;
    end else begin
      wip <= wr_busy;

      if (wr_done || cmd_wrdi) wel <= 1'b0;
      else if (cmd_wren)       wel <= 1'b1;

      if (commit_evt) begin
        nv.wpen <= pend.wpen;
        nv.lock <= pend.lock;
      end

      if (cmd_wrdi)         nv.flag <= 1'b0;
      else if (cmd_setflag) nv.flag <= 1'b1;
      else if (commit_evt)  nv.flag <= pend.flag;

      if (st_grant) begin
        pend       <= nv_from_byte(st_wdata);
        pend_valid <= 1'b1;
      end else if (wr_done) begin
        pend_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nvm_write_gate.sv
module nvm_write_gate
  import nvm_status_pkg::*;
(
  input  logic wel,
  input  logic wpen,
  input  logic wp_n,
  input  logic cmd_stwr,
  input  logic arr_wr_req,
  input  logic addr_locked,
  output logic st_grant,
  output logic arr_grant
);
  assign st_grant  = cmd_stwr & st_write_ok(wel, wpen, wp_n);
  assign arr_grant = arr_wr_req & wel & ~addr_locked;
endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
  import nvm_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter logic        RST_WPEN = 1'b0,
  parameter logic [1:0]  RST_LOCK = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_setflag,
  input  logic              cmd_stwr,
  input  logic [7:0]        st_wdata,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              wr_busy,
  input  logic              wr_done,
  output logic [7:0]        status,
  output logic              arr_grant,
  output logic              st_grant
);
  nv_bits_t nv;
  logic     wel;
  logic     wip;
  logic     commit_evt;
  logic     addr_locked;

  nvm_lock_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (arr_addr),
    .lock   (nv.lock),
    .locked (addr_locked)
  );

  nvm_write_gate u_gate (
    .wel         (wel),
    .wpen        (nv.wpen),
    .wp_n        (wp_n),
    .cmd_stwr    (cmd_stwr),
    .arr_wr_req  (arr_wr_req),
    .addr_locked (addr_locked),
    .st_grant    (st_grant),
    .arr_grant   (arr_grant)
  );

  nvm_status_regs #(.RST_WPEN(RST_WPEN), .RST_LOCK(RST_LOCK)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .cmd_setflag (cmd_setflag),
    .st_grant    (st_grant),
    .st_wdata    (st_wdata),
    .wr_busy     (wr_busy),
    .wr_done     (wr_done),
    .nv          (nv),
    .wel         (wel),
    .wip         (wip),
    .commit_evt  (commit_evt)
  );

  assign status = pack_status(nv, wel, wip);

endmodule

// File: rtl/nvm_status_guard_chk.sv
module nvm_status_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_setflag,
  input logic       cmd_stwr,
  input logic       wp_n,
  input logic       wr_busy,
  input logic       wr_done,
  input logic [7:0] status,
  input logic       arr_grant,
  input logic       st_grant,
  input logic       addr_locked,
  input logic       commit_evt
);
  assert_latch_clear_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    !status[1] |-> (!arr_grant && !st_grant));

  assert_pin_blocks_status_R4: assert property (@(posedge clk) disable iff (rst)
    (status[1] && status[7] && !wp_n) |-> !st_grant);

  assert_status_write_open_R5: assert property (@(posedge clk) disable iff (rst)
    (status[1] && (!status[7] || wp_n) && cmd_stwr) |-> st_grant);

  assert_no_grant_in_lock_R2: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> !addr_locked);

  assert_full_lock_R2: assert property (@(posedge clk) disable iff (rst)
    (status[3:2] == 2'b11) |-> !arr_grant);

  assert_latch_set_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wren && !cmd_wrdi && !wr_done) |=> status[1]);

  assert_latch_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrdi || wr_done) |=> !status[1]);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_wrdi |=> !status[6]);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_setflag && !cmd_wrdi) |=> status[6]);

  assert_nv_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !commit_evt |=> $stable({status[7], status[3:2]}));

  assert_wip_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status[0] == $past(wr_busy)));
endmodule

bind nvm_status_guard nvm_status_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_wren    (cmd_wren),
  .cmd_wrdi    (cmd_wrdi),
  .cmd_setflag (cmd_setflag),
  .cmd_stwr    (cmd_stwr),
  .wp_n        (wp_n),
  .wr_busy     (wr_busy),
  .wr_done     (wr_done),
  .status      (status),
  .arr_grant   (arr_grant),
  .st_grant    (st_grant),
  .addr_locked (addr_locked),
  .commit_evt  (commit_evt)
);

// File: tb/nvm_status_guard_bench.sv
module nvm_status_guard_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wren = 0, cmd_wrdi = 0, cmd_setflag = 0, cmd_stwr = 0;
  logic [7:0]    st_wdata = '0;
  logic          arr_wr_req = 0;
  logic [AW-1:0] arr_addr = '0;
  logic          wp_n = 1'b1, wr_busy = 0, wr_done = 0;
  logic [7:0]    status;
  logic          arr_grant, st_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvm_status_guard #(.ADDR_W(AW), .RST_WPEN(1'b1), .RST_LOCK(2'b01)) u_nvm_status_guard (
    .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_setflag(cmd_setflag), .cmd_stwr(cmd_stwr), .st_wdata(st_wdata),
    .arr_wr_req(arr_wr_req), .arr_addr(arr_addr), .wp_n(wp_n),
    .wr_busy(wr_busy), .wr_done(wr_done), .status(status),
    .arr_grant(arr_grant), .st_grant(st_grant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wren();
    cmd_wren = 1; step(); cmd_wren = 0;
  endtask

  // full status write: latch, grant, busy, completion
  task automatic write_status(input logic [7:0] val);
    pulse_wren();
    wp_n = 1; cmd_stwr = 1; st_wdata = val;
    #1 chk("R5 status write grant", st_grant, 1);
    step(); cmd_stwr = 0;
    wr_busy = 1; step();
    wr_done = 1; step();
    wr_done = 0; wr_busy = 0; step();
    chk("R8 committed status", status, {val[7], val[6], 2'b11, val[3:2], 2'b00});
  endtask

  // bench view of the lock map: quarter index against locked quarter count
  function automatic logic exp_locked(input int code, input int a);
    int q = a / (1 << (AW - 2));
    int n = (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? 2 : 4;
    return q >= (4 - n);
  endfunction

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, all R checks incomplete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0;
    // R10 / R1: reset byte with wpen=1, lock=01
    chk("R10 reset status", status, 8'hB4);
    arr_wr_req = 1; arr_addr = '0; cmd_stwr = 1; st_wdata = 8'h00;
    #1 chk("R3 arr refused, latch clear", arr_grant, 0);
    chk("R3 status refused, latch clear", st_grant, 0);
    @(negedge clk); arr_wr_req = 0; cmd_stwr = 0;

    pulse_wren();
    chk("R6 latch set", status[1], 1);
    wp_n = 0; cmd_stwr = 1;
    #1 chk("R4 status refused with pin low", st_grant, 0);
    wp_n = 1;
    #1 chk("R5 status granted with pin high", st_grant, 1);
    cmd_stwr = 0; wp_n = 0;
    @(negedge clk);

    // R2 sweep over every lock code, address and pin level
    for (int c = 0; c < 4; c++) begin
      write_status(8'h80 | 8'(c << 2));
      pulse_wren();
      for (int a = 0; a < (1 << AW); a++) begin
        for (int p = 0; p < 2; p++) begin
          arr_wr_req = 1; arr_addr = AW'(a); wp_n = p[0];
          #1 chk("R2 R4 array grant by lock map", arr_grant, !exp_locked(c, a));
          @(negedge clk);
        end
      end
      arr_wr_req = 0;
    end

    // R8: pin falls while the captured write is pending; ignored bits 5,4,1,0
    pulse_wren();
    wp_n = 1; cmd_stwr = 1; st_wdata = 8'h0F;
    #1 chk("R5 grant before pin drop", st_grant, 1);
    step(); cmd_stwr = 0; wp_n = 0; wr_busy = 1;
    step();
    chk("R9 wip follows busy", status[0], 1);
    wr_done = 1; step();
    wr_done = 0; wr_busy = 0; step();
    chk("R8 R1 write survives pin drop", status, 8'h3C);

    // R8 / R3: refused request commits nothing
    cmd_stwr = 1; st_wdata = 8'hC0;
    #1 chk("R3 refused with latch clear", st_grant, 0);
    step(); cmd_stwr = 0;
    wr_done = 1; step(); wr_done = 0; step();
    chk("R8 refused write no effect", status, 8'h3C);

    // status grant matrix over enable, latch and pin
    for (int w = 0; w < 2; w++) begin
      write_status({w[0], 7'b0});
      for (int el = 0; el < 2; el++) begin
        if (el == 1) pulse_wren();
        else begin cmd_wrdi = 1; step(); cmd_wrdi = 0; end
        for (int p = 0; p < 2; p++) begin
          wp_n = p[0]; cmd_stwr = 1; arr_wr_req = 1; arr_addr = '1;
          #1 chk("R3 R4 R5 status grant matrix", st_grant,
                 32'(el == 1 && !(w == 1 && p == 0)));
          chk("R3 R4 R5 array grant unlocked", arr_grant, 32'(el == 1));
          cmd_stwr = 0; arr_wr_req = 0;
          @(negedge clk);
        end
      end
    end

    // R7 / R6 flag and latch priorities
    cmd_setflag = 1; step(); cmd_setflag = 0;
    chk("R7 flag set", status[6], 1);
    pulse_wren();
    cmd_setflag = 1; cmd_wrdi = 1; cmd_wren = 1; step();
    cmd_setflag = 0; cmd_wrdi = 0; cmd_wren = 0;
    chk("R7 clear wins over set flag", status[6], 0);
    chk("R6 clear wins over set latch", status[1], 0);
    cmd_wren = 1; wr_done = 1; step(); cmd_wren = 0; wr_done = 0;
    chk("R6 completion wins over set latch", status[1], 0);
    wr_busy = 1; step(); wr_busy = 0;
    chk("R9 wip high one cycle later", status[0], 1);
    step();
    chk("R9 wip low again", status[0], 0);

    // R10: reset in mid-run restores defaults
    pulse_wren(); cmd_setflag = 1; step(); cmd_setflag = 0;
    rst = 1; step(); rst = 0;
    chk("R10 reset mid-run", status, 8'hB4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule